// File: doc/BRIEF.md
# Lane-Parallel Adder with Deferred Carry State

This block adds two operand vectors lane by lane, with no carry passing from one lane to the next. Each lane keeps its sum modulo 2^N. Alongside the sums, the block can update a per-lane carry state byte that a separate vector register holds. That byte counts how many carry-outs the lane has produced so far. It also records how many incoming carries the lane could still absorb without overflowing. With this record, the carries of a long chain of additions can be settled later in a single pass, by another unit.

Carry saving is armed by a request pulse. The request can come in any cycle before an addition, or in the same cycle as the addition. It applies to exactly one addition and is then cleared. An addition that is not armed copies the incoming carry state to the output unchanged. The lane datapath is purely combinational. A fused multiply-add path could therefore place the lane in front of its own output register. Results are registered one cycle after the input valid, together with an output valid.

Top module: `lane_carry_adder`

## Requirements
- R1: Each lane's sum is (a + b) mod 2^ELEM_W, and the carry-out of one lane never changes another lane's sum.
- R2: A carry state byte packs the carry-out count in bits [7:4] and the carry-in limit in bits [3:0]; lane k uses byte k of the state vectors.
- R3: In an armed addition, a lane that produces a carry-out increments its count by one, and a lane without a carry-out keeps its incoming count.
- R4: In an armed addition, every lane's limit becomes min(15, 2^ELEM_W − 1 − sum), whatever the incoming limit was.
- R5: In an armed addition, a lane whose incoming count is 15 and that produces a carry-out sets its bit of cnt_ovf and keeps a count of 15; otherwise its cnt_ovf bit is 0.
- R6: A save request applies to the next addition (in_valid high), including one in the same cycle, and only to that one; the addition after it is unarmed unless a new request arrives.
- R7: In an unarmed addition, cstate_out equals cstate_in and cnt_ovf is all zeros.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high; after reset, out_valid, sum_out, cstate_out and cnt_ovf are zero.
- R9: While in_valid is low, sum_out, cstate_out and cnt_ovf keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An addition is presented this cycle |
| save_req | input | 1 | Arms carry saving for the next addition |
| opa | input | LANES*ELEM_W | First operand vector, lane k at bits [k*ELEM_W +: ELEM_W] |
| opb | input | LANES*ELEM_W | Second operand vector |
| cstate_in | input | LANES*8 | Previous carry state vector |
| out_valid | output | 1 | Registered results are new |
| sum_out | output | LANES*ELEM_W | Lane-wise sums |
| cstate_out | output | LANES*8 | Updated carry state vector |
| cnt_ovf | output | LANES | Per-lane carry-count overflow flag |

## Verification
All operand pairs of a 5-bit lane are swept in lane 0. The other lanes receive shifted and scaled copies of those operands, so that a carry leaking between lanes shows up as a sum error beside a lane that did carry. Incoming counts cycle through every value from 0 to 15, which includes the saturated count that separates a plain increment from an overflow. The sums reach the range where the limit saturates at 15, as well as the range where the limit is exact. Additions rotate through three arming patterns: a request in an earlier cycle, a request in the same cycle, and no request right after an armed addition. These show whether arming is taken, and whether it is cleared once it has been used. Idle cycles with changed inputs test that the registered results hold.

// File: rtl/lcadd_pkg.sv
package lcadd_pkg;

    localparam int CS_W   = 8;
    localparam int FLD_W  = 4;
    localparam logic [FLD_W-1:0] FLD_MAX = '1;

    // count in the upper nibble, limit in the lower nibble
    typedef struct packed {
        logic [FLD_W-1:0] count;
        logic [FLD_W-1:0] limit;
    } cstate_t;

endpackage

// File: rtl/lcadd_arm.sv
module lcadd_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic save_req,
    output logic arm_eff
);

    typedef struct packed {
        logic armed;
    } arm_t;

    arm_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        arm_eff = st_q.armed | save_req;
        if (in_valid) begin
            st_d.armed = 1'b0;
        end else begin
            st_d.armed = arm_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // an addition always consumes the arming
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !st_q.armed);

    // a request without an addition stays pending
    p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !in_valid) |=> st_q.armed);

endmodule

// File: rtl/lcadd_lane.sv
module lcadd_lane #(
    parameter int ELEM_W = 16
) (
    input  logic [ELEM_W-1:0]    opa,
    input  logic [ELEM_W-1:0]    opb,
    input  lcadd_pkg::cstate_t   cs_in,
    input  logic                 save,
    output logic [ELEM_W-1:0]    sum,
    output lcadd_pkg::cstate_t   cs_out,
    output logic                 ovf
);
    import lcadd_pkg::*;

    logic [ELEM_W:0]   wide;
    logic              carry;
    logic [ELEM_W-1:0] room;
    logic [FLD_W-1:0]  room_sat;
    logic              at_max;

    always_comb begin
        wide  = {1'b0, opa} + {1'b0, opb};
        sum   = wide[ELEM_W-1:0];
        carry = wide[ELEM_W];
        room  = {ELEM_W{1'b1}} - sum;
    end

    generate
        if (ELEM_W > FLD_W) begin : g_sat
            always_comb begin
                room_sat = (|room[ELEM_W-1:FLD_W]) ? FLD_MAX : room[FLD_W-1:0];
            end
        end else begin : g_fit
            always_comb begin
                room_sat = room;
            end
        end
    endgenerate

    always_comb begin
        at_max = (cs_in.count == FLD_MAX);
        cs_out = cs_in;
        ovf    = 1'b0;
        if (save) begin
            cs_out.limit = room_sat;
            if (carry) begin
                if (at_max) begin
                    ovf = 1'b1;
                end else begin
                    cs_out.count = cs_in.count + 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/lane_carry_adder.sv
module lane_carry_adder #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     save_req,
    input  logic [LANES*ELEM_W-1:0]  opa,
    input  logic [LANES*ELEM_W-1:0]  opb,
    input  logic [LANES*8-1:0]       cstate_in,
    output logic                     out_valid,
    output logic [LANES*ELEM_W-1:0]  sum_out,
    output logic [LANES*8-1:0]       cstate_out,
    output logic [LANES-1:0]         cnt_ovf
);
    import lcadd_pkg::*;

    localparam int VEC_W = LANES * ELEM_W;
    localparam int CSV_W = LANES * CS_W;

    typedef struct packed {
        logic              valid;
        logic              saved;
        logic [VEC_W-1:0]  sum;
        logic [CSV_W-1:0]  cs;
        logic [LANES-1:0]  ovf;
    } stage_t;

    stage_t st_d, st_q;

    logic              arm_eff;
    logic [VEC_W-1:0]  lane_sum;
    logic [CSV_W-1:0]  lane_cs;
    logic [LANES-1:0]  lane_ovf;

    lcadd_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .save_req (save_req),
        .arm_eff  (arm_eff)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            cstate_t cs_i, cs_o;
            always_comb cs_i = cstate_in[g*CS_W +: CS_W];

            lcadd_lane #(.ELEM_W(ELEM_W)) u_lane (
                .opa    (opa[g*ELEM_W +: ELEM_W]),
                .opb    (opb[g*ELEM_W +: ELEM_W]),
                .cs_in  (cs_i),
                .save   (arm_eff),
                .sum    (lane_sum[g*ELEM_W +: ELEM_W]),
                .cs_out (cs_o),
                .ovf    (lane_ovf[g])
            );
            always_comb lane_cs[g*CS_W +: CS_W] = cs_o;

            // count moves by at most one, or the lane flags overflow
            p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && arm_eff) |=>
                    (cstate_out[g*CS_W+FLD_W +: FLD_W] == $past(cstate_in[g*CS_W+FLD_W +: FLD_W])) ||
                    (cstate_out[g*CS_W+FLD_W +: FLD_W] == $past(cstate_in[g*CS_W+FLD_W +: FLD_W]) + 4'd1) ||
                    cnt_ovf[g]);

            // an unsaturated limit plus the sum reaches the all-ones value
            p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && st_q.saved && (cstate_out[g*CS_W +: FLD_W] != FLD_MAX)) |->
                    ((sum_out[g*ELEM_W +: ELEM_W] + ELEM_W'(cstate_out[g*CS_W +: FLD_W]))
                        == {ELEM_W{1'b1}}));

            p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_ovf[g] |-> (cstate_out[g*CS_W+FLD_W +: FLD_W] == FLD_MAX));
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.saved = arm_eff;
            st_d.sum   = lane_sum;
            st_d.cs    = lane_cs;
            st_d.ovf   = lane_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        out_valid  = st_q.valid;
        sum_out    = st_q.sum;
        cstate_out = st_q.cs;
        cnt_ovf    = st_q.ovf;
    end

    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !arm_eff) |=> (cstate_out == $past(cstate_in)) && (cnt_ovf == '0));

    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out) && $stable(cstate_out) && $stable(cnt_ovf));

endmodule

// File: tb/tb_lane_carry_adder.sv
`timescale 1ns/1ps
module tb_lane_carry_adder;

    localparam int LANES  = 3;
    localparam int ELEM_W = 5;
    localparam int VEC_W  = LANES * ELEM_W;
    localparam int MAXV   = (1 << ELEM_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               save_req = 1'b0;
    logic [VEC_W-1:0]   opa = '0;
    logic [VEC_W-1:0]   opb = '0;
    logic [LANES*8-1:0] cstate_in = '0;
    logic               out_valid;
    logic [VEC_W-1:0]   sum_out;
    logic [LANES*8-1:0] cstate_out;
    logic [LANES-1:0]   cnt_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lane_carry_adder #(.LANES(LANES), .ELEM_W(ELEM_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .save_req   (save_req),
        .opa        (opa),
        .opb        (opb),
        .cstate_in  (cstate_in),
        .out_valid  (out_valid),
        .sum_out    (sum_out),
        .cstate_out (cstate_out),
        .cnt_ovf    (cnt_ovf)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int ea [LANES];
        int eb [LANES];
        int ecnt [LANES];
        int elim [LANES];
        logic [VEC_W-1:0] held_sum;
        logic [LANES*8-1:0] held_cs;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset valid", int'(out_valid), 0);
        check("R8 reset sum", int'(sum_out), 0);
        check("R8 reset cstate", int'(cstate_out), 0);
        check("R8 reset ovf", int'(cnt_ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 1024; i++) begin
            int mode;
            bit armed;
            int a0;
            int b0;
            mode  = i % 3;
            armed = (mode != 1);
            a0 = i % 32;
            b0 = i / 32;
            if (mode == 2) begin
                // R6 request one cycle ahead of the addition
                save_req = 1'b1;
                @(negedge clk);
                save_req = 1'b0;
            end
            for (int l = 0; l < LANES; l++) begin
                ea[l]   = (a0 + 7 * l) % 32;
                eb[l]   = (b0 * (l + 1) + l) % 32;
                ecnt[l] = (i + 5 * l) % 16;
                elim[l] = (i * 3 + l) % 16;
                opa[l*ELEM_W +: ELEM_W] = ELEM_W'(ea[l]);
                opb[l*ELEM_W +: ELEM_W] = ELEM_W'(eb[l]);
                cstate_in[l*8 +: 8] = {4'(ecnt[l]), 4'(elim[l])};
            end
            in_valid = 1'b1;
            save_req = (mode == 0);
            @(negedge clk);
            in_valid = 1'b0;
            save_req = 1'b0;
            check("R8 valid after add", int'(out_valid), 1);
            for (int l = 0; l < LANES; l++) begin
                int tot;
                int s;
                int co;
                int xc;
                int xl;
                int xo;
                tot = ea[l] + eb[l];
                s   = tot % 32;
                co  = (tot > MAXV) ? 1 : 0;
                check("R1 lane sum", int'(sum_out[l*ELEM_W +: ELEM_W]), s);
                if (armed) begin
                    xc = (co == 1 && ecnt[l] < 15) ? ecnt[l] + 1 : ecnt[l];
                    xo = (co == 1 && ecnt[l] == 15) ? 1 : 0;
                    xl = (MAXV - s > 15) ? 15 : MAXV - s;
                    check(mode == 2 ? "R6 early arm count" : "R3 count",
                          int'(cstate_out[l*8+4 +: 4]), xc);
                    check("R4 limit", int'(cstate_out[l*8 +: 4]), xl);
                    check("R5 overflow", int'(cnt_ovf[l]), xo);
                    check("R2 byte layout", int'(cstate_out[l*8 +: 8]), xc * 16 + xl);
                end else begin
                    check("R7 passthrough", int'(cstate_out[l*8 +: 8]), ecnt[l] * 16 + elim[l]);
                    check("R6 disarmed ovf", int'(cnt_ovf[l]), 0);
                end
            end
            if (i % 64 == 5) begin
                held_sum = sum_out;
                held_cs  = cstate_out;
                opa = ~opa;
                cstate_in = ~cstate_in;
                save_req = 1'b1;
                @(negedge clk);
                save_req = 1'b0;
                @(negedge clk);
                check("R8 idle valid", int'(out_valid), 0);
                check("R9 hold sum", int'(sum_out), int'(held_sum));
                check("R9 hold cstate", int'(cstate_out), int'(held_cs));
                // the pending arm is consumed by an addition with zero operands
                opa = '0;
                opb = '0;
                cstate_in = {LANES{8'h3A}};
                in_valid = 1'b1;
                @(negedge clk);
                in_valid = 1'b0;
                for (int l = 0; l < LANES; l++) begin
                    check("R6 pending arm", int'(cstate_out[l*8 +: 8]), 8'h3F);
                end
            end
        end
        done = 1'b1;
        finish_run();
    end

endmodule